// File: doc/BRIEF.md
# Product-Term Macrocell with Term Expanders

This block is one logic cell of a sum-of-products device. A programmable AND plane builds five product terms from a literal set. The set holds every input in true and in complemented form, plus the shareable-expander lines that arrive from neighbouring cells. A fixed OR stage adds the terms into one sum. That sum reaches the output either straight through or through a single programmable register. The register can run as a D, T, JK or SR flip-flop. It has a clock enable, an asynchronous clear and an asynchronous preset. Its clock is either the global clock or a clock formed by a product term.

Some terms have a second role. One term can serve as the K or R input of the register. One can serve as the register clock. One can be exported to other cells as a shareable expander. A term given one of these roles leaves the local sum. Parallel expanders link cells in a chain: a cell can pass its whole sum to the next cell on `par_out`, and it can add the sum arriving on `par_in`. With five terms per cell, a chain of four cells puts up to 20 product terms into one output.

All configuration bits are loaded serially before use. A small state machine counts the load cycles and controls the outputs. The machine is in one of three states:
- `LD_EMPTY`: unconfigured.
- `LD_SHIFT`: a load is in progress.
- `LD_READY`: the cell is configured.

It moves between them on these transitions:
- From `LD_EMPTY` or `LD_READY`, `cfg_load` high starts a load and the machine goes to `LD_SHIFT`.
- In `LD_SHIFT`, the cycle that shifts the last bit moves the machine to `LD_READY`.
- In `LD_SHIFT`, `cfg_load` falling before the count is complete sends the machine back to `LD_EMPTY`.
- Without `cfg_load`, the machine stays in `LD_EMPTY` or `LD_READY`.

Top module: `pterm_macrocell`

## Requirements
- R1: After reset, and in every cycle in which the loader is not in `LD_READY`, `mc_out`, `shr_out` and `par_out` are 0.
- R2: Loading takes exactly CFG_W (58 by default) consecutive cycles with `cfg_load` high, and `cfg_bit` is sampled at each rising `gclk` edge. The first bit becomes configuration bit CFG_W-1, so the bits go in MSB first. If `cfg_load` drops before the count is complete, the loader returns to `LD_EMPTY`. While ready with `cfg_load` low, the configuration does not change.
- R3: Configuration bit 8 + t*10 + l selects literal l for term t. For literals 0..3 the literal is `x_in[l]`, for 4..7 it is `~x_in[l-4]`, and for 8..9 it is `shr_in[l-8]`. A term is the AND of its selected literals, and a term that selects no literal is 0.
- R4: The sum is the OR of every term that has no other role. When bit 3 (chain-in enable) is 1, `par_in` is also ORed into the sum; when bit 3 is 0, `par_in` has no effect.
- R5: When bit 5 (share enable) is 1, term 2 drives `shr_out` and leaves the sum. Otherwise `shr_out` is 0.
- R6: When bit 4 (lend) is 1, `par_out` carries the sum and the cell's own function is 0. Otherwise `par_out` is 0.
- R7: When bit 2 (bypass) is 1, `mc_out` is the combinational function. When bit 2 is 0, `mc_out` is the register output.
- R8: Register mode bits [1:0] select the flip-flop type: 0 is D, 1 is T, 2 is JK and 3 is SR. In D mode the register loads the function. In T mode it toggles when the function is 1 and holds when it is 0.
- R9: When bit 7 (aux enable) is 1, term 4 leaves the sum and becomes the K or R input. In JK mode, J is the function: J=1,K=0 sets; J=0,K=1 clears; J=K=1 toggles; J=K=0 holds.
- R10: In SR mode, S is the function and R is term 4: S=1,R=0 sets; S=0,R=1 clears; S=R=1 holds.
- R11: The register updates only on clock edges at which `gena` is 1.
- R12: `mc_pre` sets and `mc_clr` clears the register at once, without a clock. When both are high, clear wins.
- R13: When bit 6 (term clock) is 1, term 3 leaves the sum and its rising edge clocks the register, and `gclk` edges no longer update the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gclk | input | 1 | Global clock for the loader and the default register clock |
| grst_n | input | 1 | Active-low asynchronous reset of the loader and the register |
| gena | input | 1 | Register clock enable |
| mc_clr | input | 1 | Asynchronous register clear, active high |
| mc_pre | input | 1 | Asynchronous register preset, active high |
| cfg_load | input | 1 | Serial configuration load enable |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| x_in | input | N_IN | Input signals feeding the AND plane |
| shr_in | input | N_SHR | Shareable-expander terms from neighbouring cells |
| par_in | input | 1 | Parallel-expander sum from the previous cell |
| shr_out | output | 1 | Exported shareable-expander term |
| par_out | output | 1 | Sum lent to the next cell |
| mc_out | output | 1 | Macrocell output |

## Verification
The assertions assume the following about the inputs:
- `mc_clr` and `mc_pre` are never released at the same instant as a clock edge.
- Inputs change only away from rising `gclk` edges.
- The literals that form a term clock do not glitch.

The stimulus keeps within these limits. Every input changes on the falling edge of `gclk`, and the asynchronous controls are pulsed between edges. When term 3 serves as the clock, only the single input feeding it moves, and it moves only after the data term is already stable. The checker keeps its own count of consecutive load cycles. It therefore assumes that reset is applied before the first load and that `cfg_load` has no X values.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        FF_D  = 2'd0,
        FF_T  = 2'd1,
        FF_JK = 2'd2,
        FF_SR = 2'd3
    } ff_mode_e;

    typedef enum logic [1:0] {
        LD_EMPTY = 2'd0,
        LD_SHIFT = 2'd1,
        LD_READY = 2'd2
    } ld_state_e;

    // Control field positions at the bottom of the configuration word
    localparam int CTRL_W    = 8;
    localparam int B_BYPASS  = 2;
    localparam int B_CHAIN   = 3;
    localparam int B_LEND    = 4;
    localparam int B_SHARE   = 5;
    localparam int B_PTCLK   = 6;
    localparam int B_AUX     = 7;

endpackage

// File: rtl/mc_cfg_loader.sv
module mc_cfg_loader
    import mc_pkg::*;
#(
    parameter int CFG_W = 58
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             bit_in,
    output logic [CFG_W-1:0] cfg,
    output logic             ready
);

    localparam int CNT_W = $clog2(CFG_W + 1);

    ld_state_e        state, state_nxt;
    logic [CNT_W-1:0] cnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LD_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            LD_EMPTY, LD_READY: begin
                if (load) begin
                    state_nxt = LD_SHIFT;
                end
            end
            LD_SHIFT: begin
                if (!load) begin
                    state_nxt = LD_EMPTY;
                end else if (cnt == CNT_W'(CFG_W - 1)) begin
                    state_nxt = LD_READY;
                end
            end
            default: state_nxt = LD_EMPTY;
        endcase
    end

    // Shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
            cnt <= '0;
        end else if (load) begin
            cfg <= {cfg[CFG_W-2:0], bit_in};
            cnt <= (state == LD_SHIFT) ? cnt + 1'b1 : CNT_W'(1);
        end else begin
            cnt <= '0;
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            LD_READY: ready = 1'b1;
            default:  ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/mc_and_plane.sv
module mc_and_plane #(
    parameter int N_LIT = 10,
    parameter int N_PT  = 5
) (
    input  logic [N_LIT-1:0]      lits,
    input  logic [N_PT*N_LIT-1:0] mask,
    output logic [N_PT-1:0]       terms
);

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        logic [N_LIT-1:0] sel;
        assign sel      = mask[t*N_LIT +: N_LIT];
        // An unused literal counts as 1; a term with no literal at all is off
        assign terms[t] = (|sel) & (&(lits | ~sel));
    end

endmodule

// File: rtl/mc_pff.sv
module mc_pff
    import mc_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  logic     pre,
    input  logic     en,
    input  ff_mode_e mode,
    input  logic     s_in,
    input  logic     r_in,
    output logic     q
);

    logic q_nxt;

    always_comb begin
        unique case (mode)
            FF_D:  q_nxt = s_in;
            FF_T:  q_nxt = q ^ s_in;
            FF_JK: q_nxt = (s_in & ~q) | (~r_in & q);
            FF_SR: q_nxt = (s_in & ~r_in) | (q & ~(s_in ^ r_in)) | (q & s_in & r_in);
            default: q_nxt = q;
        endcase
    end

    always_ff @(posedge clk or posedge clr or posedge pre) begin
        if (clr) begin
            q <= 1'b0;
        end else if (pre) begin
            q <= 1'b1;
        end else if (en) begin
            q <= q_nxt;
        end
    end

endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell
    import mc_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_SHR = 2,
    parameter int N_PT  = 5   // at least 4: three terms carry extra roles
) (
    input  logic             gclk,
    input  logic             grst_n,
    input  logic             gena,
    input  logic             mc_clr,
    input  logic             mc_pre,
    input  logic             cfg_load,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  x_in,
    input  logic [N_SHR-1:0] shr_in,
    input  logic             par_in,
    output logic             shr_out,
    output logic             par_out,
    output logic             mc_out
);

    localparam int N_LIT  = 2 * N_IN + N_SHR;
    localparam int MASK_W = N_PT * N_LIT;
    localparam int CFG_W  = CTRL_W + MASK_W;
    localparam int T_AUX  = N_PT - 1;
    localparam int T_CLK  = N_PT - 2;
    localparam int T_SHR  = N_PT - 3;

    logic [CFG_W-1:0] cfg_vec;
    logic             ready;

    mc_cfg_loader #(.CFG_W(CFG_W)) u_load (
        .clk    (gclk),
        .rst_n  (grst_n),
        .load   (cfg_load),
        .bit_in (cfg_bit),
        .cfg    (cfg_vec),
        .ready  (ready)
    );

    logic [N_LIT-1:0] lits;
    logic [N_PT-1:0]  terms;

    assign lits = {shr_in, ~x_in, x_in};

    mc_and_plane #(.N_LIT(N_LIT), .N_PT(N_PT)) u_and (
        .lits  (lits),
        .mask  (cfg_vec[CFG_W-1:CTRL_W]),
        .terms (terms)
    );

    logic bypass, chain_en, lend_en, share_en, ptclk_en, aux_en;
    assign bypass   = cfg_vec[B_BYPASS];
    assign chain_en = cfg_vec[B_CHAIN];
    assign lend_en  = cfg_vec[B_LEND];
    assign share_en = cfg_vec[B_SHARE];
    assign ptclk_en = cfg_vec[B_PTCLK];
    assign aux_en   = cfg_vec[B_AUX];

    // Terms given a special role drop out of the fixed OR
    logic [N_PT-1:0] keep;
    always_comb begin
        keep = '1;
        if (aux_en)   keep[T_AUX] = 1'b0;
        if (ptclk_en) keep[T_CLK] = 1'b0;
        if (share_en) keep[T_SHR] = 1'b0;
    end

    logic sum, cell_f, r_in, reg_clk, clr_any, ff_q;
    assign sum     = (|(terms & keep)) | (chain_en & par_in);
    assign cell_f  = lend_en ? 1'b0 : sum;
    assign r_in    = aux_en & terms[T_AUX];
    assign reg_clk = ptclk_en ? terms[T_CLK] : gclk;
    assign clr_any = mc_clr | ~grst_n;

    mc_pff u_ff (
        .clk  (reg_clk),
        .clr  (clr_any),
        .pre  (mc_pre),
        .en   (gena & ready),
        .mode (ff_mode_e'(cfg_vec[1:0])),
        .s_in (cell_f),
        .r_in (r_in),
        .q    (ff_q)
    );

    assign mc_out  = ready & (bypass ? cell_f : ff_q);
    assign shr_out = ready & share_en & terms[T_SHR];
    assign par_out = ready & lend_en & sum;

endmodule

// File: rtl/mc_chk.sv
module mc_chk #(
    parameter int CFG_W = 58
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             gena,
    input logic             clr,
    input logic             pre,
    input logic             q,
    input logic [CFG_W-1:0] cfg,
    input logic             mc_out,
    input logic             shr_out,
    input logic             par_out
);

    localparam int CNT_W = $clog2(CFG_W + 1);

    // Independent model of "configured": CFG_W consecutive load cycles
    logic [CNT_W-1:0] seen;
    logic             ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
            ok   <= 1'b0;
        end else if (load) begin
            if (seen == CNT_W'(CFG_W - 1)) begin
                seen <= '0;
                ok   <= 1'b1;
            end else begin
                seen <= seen + 1'b1;
                ok   <= 1'b0;
            end
        end else begin
            if (seen != '0) ok <= 1'b0;
            seen <= '0;
        end
    end

    // R1
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ok |-> (mc_out == 1'b0 && shr_out == 1'b0 && par_out == 1'b0));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !load) |=> $stable(cfg));

    // R12
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !q);

    // R12
    pre_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre && !clr) |-> q);

    // R11
    gena_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gena && !clr && !pre) |=> (clr || pre || $stable(q)));

endmodule

bind pterm_macrocell mc_chk #(.CFG_W(CFG_W)) u_chk (
    .clk     (gclk),
    .rst_n   (grst_n),
    .load    (cfg_load),
    .gena    (gena),
    .clr     (mc_clr),
    .pre     (mc_pre),
    .q       (ff_q),
    .cfg     (cfg_vec),
    .mc_out  (mc_out),
    .shr_out (shr_out),
    .par_out (par_out)
);

// File: tb/pterm_macrocell_tb.sv
`timescale 1ns/1ps
module pterm_macrocell_tb;

    localparam int N_IN  = 4;
    localparam int N_SHR = 2;
    localparam int N_PT  = 5;
    localparam int N_LIT = 2 * N_IN + N_SHR;
    localparam int CFG_W = 8 + N_PT * N_LIT;

    logic             gclk = 1'b0;
    logic             grst_n = 1'b0;
    logic             gena = 1'b1;
    logic             mc_clr = 1'b0;
    logic             mc_pre = 1'b0;
    logic             cfg_load = 1'b0;
    logic             cfg_bit = 1'b0;
    logic [N_IN-1:0]  x_in = '0;
    logic [N_SHR-1:0] shr_in = '0;
    logic             par_in = 1'b0;
    logic             shr_out, par_out, mc_out;

    int checks = 0;
    int fails  = 0;

    always #10 gclk = ~gclk;

    pterm_macrocell #(.N_IN(N_IN), .N_SHR(N_SHR), .N_PT(N_PT)) u_dut (
        .gclk(gclk), .grst_n(grst_n), .gena(gena), .mc_clr(mc_clr), .mc_pre(mc_pre),
        .cfg_load(cfg_load), .cfg_bit(cfg_bit), .x_in(x_in), .shr_in(shr_in),
        .par_in(par_in), .shr_out(shr_out), .par_out(par_out), .mc_out(mc_out)
    );

    // Fields: x[8:5] shr[4:3] par[2] expected mc_out[1] expected shr_out[0]
    localparam logic [8:0] VECS [10] = '{
        9'b0100_00_0_0_0,
        9'b0111_00_0_1_0,
        9'b0000_00_0_1_0,
        9'b1100_00_0_0_1,
        9'b1100_01_0_1_1,
        9'b1101_01_0_1_0,
        9'b0101_01_0_0_0,
        9'b0101_00_1_1_0,
        9'b0101_10_0_0_0,
        9'b1110_00_0_0_1
    };

    function automatic int mb(input int t, input int l);
        return 8 + t * N_LIT + l;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [CFG_W-1:0] v, input int nbits);
        for (int i = CFG_W - 1; i >= CFG_W - nbits; i--) begin
            @(negedge gclk);
            cfg_load = 1'b1;
            cfg_bit  = v[i];
        end
        @(negedge gclk);
        cfg_load = 1'b0;
    endtask

    // Called at a falling edge: apply x, pass one rising edge, check
    task automatic clk_step(input logic [3:0] xv, input logic exp, input string tag);
        x_in = xv;
        @(negedge gclk);
        check(mc_out, exp, tag);
    endtask

    task automatic clr_pulse();
        @(negedge gclk);
        mc_clr = 1'b1;
        @(negedge gclk);
        mc_clr = 1'b0;
    endtask

    initial begin
        #4_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [CFG_W-1:0] ca, cb, cd, ct, cjk, csr, cpc;

        // Config A: bypass, chain-in, share term 2, D mode
        ca = '0;
        ca[2] = 1'b1; ca[3] = 1'b1; ca[5] = 1'b1;
        ca[mb(0, 0)] = 1'b1; ca[mb(0, 1)] = 1'b1;   // x0 & x1
        ca[mb(1, 6)] = 1'b1;                        // ~x2
        ca[mb(2, 3)] = 1'b1; ca[mb(2, 4)] = 1'b1;   // x3 & ~x0 (shared)
        ca[mb(3, 8)] = 1'b1; ca[mb(3, 3)] = 1'b1;   // shr0 & x3

        // Config B: lend, bypass, ~x2 only, no chain-in
        cb = '0;
        cb[2] = 1'b1; cb[4] = 1'b1;
        cb[mb(1, 6)] = 1'b1;

        // Register configs: term 0 = x0, term 4 = x1 as K/R
        cd = '0; cd[mb(0, 0)] = 1'b1;
        ct = cd; ct[1:0] = 2'd1;
        cjk = cd; cjk[1:0] = 2'd2; cjk[7] = 1'b1; cjk[mb(4, 1)] = 1'b1;
        csr = cjk; csr[1:0] = 2'd3;
        cpc = cd; cpc[6] = 1'b1; cpc[mb(3, 3)] = 1'b1;   // term 3 = x3 as clock

        // R1: reset and unconfigured state
        repeat (3) @(negedge gclk);
        check(mc_out, 1'b0, "R1 mc_out in reset");
        grst_n = 1'b1;
        @(negedge gclk);
        check(mc_out, 1'b0, "R1 mc_out unconfigured");
        check(shr_out, 1'b0, "R1 shr_out unconfigured");
        check(par_out, 1'b0, "R1 par_out unconfigured");

        // R2: an incomplete load leaves the cell unconfigured
        load_cfg(ca, CFG_W - 1);
        @(negedge gclk);
        x_in = 4'b0000;
        #2 check(mc_out, 1'b0, "R2 partial load keeps output low");
        load_cfg(ca, CFG_W);
        #2 check(mc_out, 1'b1, "R2 full load enables output");

        // R3 R4 R5: vector walk through config A
        for (int k = 0; k < 10; k++) begin
            @(negedge gclk);
            x_in   = VECS[k][8:5];
            shr_in = VECS[k][4:3];
            par_in = VECS[k][2];
            #2;
            check(mc_out, VECS[k][1], $sformatf("R3 R4 vector %0d mc_out", k));
            check(shr_out, VECS[k][0], $sformatf("R5 vector %0d shr_out", k));
            check(par_out, 1'b0, $sformatf("R6 vector %0d par_out idle", k));
        end
        shr_in = '0;
        par_in = 1'b0;

        // R6 R4: lending the sum
        load_cfg(cb, CFG_W);
        x_in = 4'b0000;
        #2;
        check(par_out, 1'b1, "R6 lent sum on par_out");
        check(mc_out, 1'b0, "R6 own function zero when lending");
        x_in = 4'b0100; par_in = 1'b1;
        #2 check(par_out, 1'b0, "R4 par_in ignored without chain-in");
        par_in = 1'b0;

        // R7 R8 R11: D register
        load_cfg(cd, CFG_W);
        clr_pulse();
        clk_step(4'b0001, 1'b1, "R7 R8 D loads 1");
        gena = 1'b0;
        clk_step(4'b0000, 1'b1, "R11 enable low holds");
        gena = 1'b1;
        clk_step(4'b0000, 1'b0, "R8 D loads 0");

        // R12: asynchronous preset and clear
        mc_pre = 1'b1;
        #2 check(mc_out, 1'b1, "R12 preset without clock");
        mc_clr = 1'b1;
        #2 check(mc_out, 1'b0, "R12 clear wins over preset");
        @(negedge gclk);
        mc_pre = 1'b0;
        #2 mc_clr = 1'b0;

        // R8: T register
        load_cfg(ct, CFG_W);
        clr_pulse();
        clk_step(4'b0001, 1'b1, "R8 T toggles up");
        clk_step(4'b0001, 1'b0, "R8 T toggles down");
        clk_step(4'b0000, 1'b0, "R8 T holds");

        // R9: JK register
        load_cfg(cjk, CFG_W);
        clr_pulse();
        clk_step(4'b0001, 1'b1, "R9 JK set");
        clk_step(4'b0010, 1'b0, "R9 JK clear");
        clk_step(4'b0011, 1'b1, "R9 JK toggle up");
        clk_step(4'b0011, 1'b0, "R9 JK toggle down");
        clk_step(4'b0001, 1'b1, "R9 JK set again");
        clk_step(4'b0000, 1'b1, "R9 JK hold");

        // R10: SR register
        load_cfg(csr, CFG_W);
        clr_pulse();
        clk_step(4'b0001, 1'b1, "R10 SR set");
        clk_step(4'b0011, 1'b1, "R10 SR both high holds 1");
        clk_step(4'b0010, 1'b0, "R10 SR reset");
        clk_step(4'b0011, 1'b0, "R10 SR both high holds 0");

        // R13: product-term clock
        x_in = 4'b0000;
        load_cfg(cpc, CFG_W);
        clr_pulse();
        x_in = 4'b0001;
        repeat (3) @(negedge gclk);
        check(mc_out, 1'b0, "R13 global clock ignored");
        x_in = 4'b1001;
        #2 check(mc_out, 1'b1, "R13 term clock edge loads");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule